// File: doc/BRIEF.md
# Half-width brain-float adder and subtractor

This unit adds or subtracts two 16-bit brain-float numbers. Each word has a sign bit, an 8-bit biased exponent (bias 127) and a 7-bit stored fraction. This is the top half of a single-precision word. Both operands are assumed to be normalized. The result is a normalized word of the same layout.

A one-bit select chooses addition or subtraction. Subtraction works by inverting the second operand's sign bit, so one datapath serves both operations. Each computation is issued with a valid strobe. The answer is registered and appears one clock later.

The datapath has these steps:
- Find the larger magnitude.
- Align the smaller significand by a right shift that drops the bits shifted out.
- Add or subtract the significands.
- Renormalize the result.

There is no rounding, no overflow or underflow handling, and no support for special values. Zero operands and exact cancellation are handled on their own path.

Top module: `bf16_addsub`

## Requirements
- R1: A word whose bits [14:0] are all zero is zero, whatever its sign bit (bit 15). Any other word has an implicit leading one above its fraction (bits [6:0]). Its exponent is in bits [14:7].
- R2: With `sub_sel` = 0 the result is `op_a + op_b`. With `sub_sel` = 1 it is `op_a - op_b`. For example, 0x3F40 - 0x40A0 gives 0xC088 and 0x3F40 + 0x40A0 gives 0x40B8.
- R3: After reset, `out_valid` is 0 and `result` is 0x0000. When `in_valid` is high at a rising edge, the answer appears on `result` at that edge, and `out_valid` is high exactly one edge after each accepted operand pair.
- R4: If exactly one operand is zero, the result is the other operand. When `op_b` is the nonzero one and `sub_sel` = 1, its sign bit is inverted. If both operands are zero, the result is 0x0000.
- R5: The operand with the larger magnitude (compared by exponent, then by fraction) sets the result exponent before renormalization. The other significand is shifted right by the exponent difference, and shifted-out bits are lost. A difference of 8 or more returns the larger operand unchanged.
- R6: When the effective signs agree, the significands are added and the result keeps that sign. A carry out of the 8-bit significand shifts the sum right by one and raises the exponent by one.
- R7: When the effective signs differ, the smaller significand is subtracted from the larger. The result takes the sign of the larger-magnitude operand. It is shifted left until its leading one reaches the hidden position, and the exponent is lowered by the same count.
- R8: Operands of equal magnitude with opposite effective signs give 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair and select are presented this cycle |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| sub_sel | input | 1 | 0 selects addition, 1 selects subtraction |
| out_valid | output | 1 | `result` holds a fresh answer |
| result | output | 16 | Registered sum or difference |

## Verification
Directed pairs each target one branch of the datapath:
- A same-sign add without carry and one with carry separate the two post-add shifts.
- A one-unit difference forces the deepest left normalization.
- Exponent gaps of 7 and 8 probe the alignment cut-off.
- Swapped operand order and equal exponents with different fractions test the magnitude comparison and the sign it selects.
- Signed zeros and equal magnitudes exercise the bypass path and cancellation.

Random pairs from a moderate exponent band are then checked against an integer model. That model aligns with truncation and normalizes by iteration.

// File: rtl/bf16_pkg.sv
package bf16_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 7;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int SIG_W  = MAN_W + 1;
  localparam int LZ_W   = $clog2(SIG_W + 1);

  typedef struct packed {
    logic             sgn;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } bf16_t;

  // zero test ignores the sign bit
  function automatic logic is_zero(bf16_t v);
    return (v.exp == '0) && (v.man == '0);
  endfunction

  // magnitude ordering: exponent first, then fraction
  function automatic logic mag_ge(bf16_t x, bf16_t y);
    return {x.exp, x.man} >= {y.exp, y.man};
  endfunction

  // count of zero bits above the leading one
  function automatic logic [LZ_W-1:0] lead_zeros(logic [SIG_W-1:0] v);
    logic [LZ_W-1:0] n;
    logic            found;
    n     = '0;
    found = 1'b0;
    for (int i = SIG_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (v[i]) found = 1'b1;
        else      n = n + 1'b1;
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/bf16_align.sv
module bf16_align
  import bf16_pkg::*;
(
  input  bf16_t             op_x,
  input  bf16_t             op_y,
  output logic              big_sgn,
  output logic [EXP_W-1:0]  big_exp,
  output logic [SIG_W-1:0]  big_sig,
  output logic [SIG_W-1:0]  small_sig,
  output logic              eff_sub,
  output logic              swap
);
  logic [EXP_W-1:0] small_exp;
  logic [MAN_W-1:0] big_man, small_man;
  logic [EXP_W-1:0] gap;

  always_comb begin
    swap      = !mag_ge(op_x, op_y);
    big_sgn   = swap ? op_y.sgn : op_x.sgn;
    big_exp   = swap ? op_y.exp : op_x.exp;
    big_man   = swap ? op_y.man : op_x.man;
    small_exp = swap ? op_x.exp : op_y.exp;
    small_man = swap ? op_x.man : op_y.man;
    eff_sub   = op_x.sgn ^ op_y.sgn;
    gap       = big_exp - small_exp;
    big_sig   = {1'b1, big_man};
    if (gap >= EXP_W'(SIG_W)) small_sig = '0;
    else                      small_sig = {1'b1, small_man} >> gap;
  end
endmodule

// File: rtl/bf16_combine.sv
module bf16_combine
  import bf16_pkg::*;
(
  input  logic              big_sgn,
  input  logic [EXP_W-1:0]  big_exp,
  input  logic [SIG_W-1:0]  big_sig,
  input  logic [SIG_W-1:0]  small_sig,
  input  logic              eff_sub,
  output bf16_t             res,
  output logic              carry,
  output logic              cancel,
  output logic              lead
);
  logic [SIG_W:0]   sum;
  logic [SIG_W-1:0] dif;
  logic [SIG_W-1:0] norm;
  logic [LZ_W-1:0]  lz;

  always_comb begin
    sum    = {1'b0, big_sig} + {1'b0, small_sig};
    dif    = big_sig - small_sig;
    lz     = lead_zeros(dif);
    norm   = dif << lz;
    lead   = norm[SIG_W-1];
    cancel = eff_sub && (dif == '0);
    carry  = !eff_sub && sum[SIG_W];
    res.sgn = big_sgn;
    if (!eff_sub) begin
      if (sum[SIG_W]) begin
        res.exp = big_exp + 1'b1;
        res.man = sum[SIG_W-1:1];
      end else begin
        res.exp = big_exp;
        res.man = sum[MAN_W-1:0];
      end
    end else begin
      res.exp = big_exp - EXP_W'(lz);
      res.man = norm[MAN_W-1:0];
    end
    if (cancel) res = '0;
  end
endmodule

// File: rtl/bf16_addsub.sv
module bf16_addsub
  import bf16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              sub_sel,
  output logic              out_valid,
  output logic [WORD_W-1:0] result
);
  bf16_t            a_w, b_eff_w, dp_res, nxt;
  logic             za, zb;
  logic             big_sgn_w, eff_sub_w, swap_w;
  logic [EXP_W-1:0] big_exp_w;
  logic [SIG_W-1:0] big_sig_w, small_sig_w;
  logic             dp_carry, cancel_w, lead_w, carry_w;

  assign a_w     = op_a;
  assign b_eff_w = {op_b[WORD_W-1] ^ sub_sel, op_b[WORD_W-2:0]};
  assign za      = is_zero(a_w);
  assign zb      = is_zero(b_eff_w);

  bf16_align u_align (
    .op_x      (a_w),
    .op_y      (b_eff_w),
    .big_sgn   (big_sgn_w),
    .big_exp   (big_exp_w),
    .big_sig   (big_sig_w),
    .small_sig (small_sig_w),
    .eff_sub   (eff_sub_w),
    .swap      (swap_w)
  );

  bf16_combine u_combine (
    .big_sgn   (big_sgn_w),
    .big_exp   (big_exp_w),
    .big_sig   (big_sig_w),
    .small_sig (small_sig_w),
    .eff_sub   (eff_sub_w),
    .res       (dp_res),
    .carry     (dp_carry),
    .cancel    (cancel_w),
    .lead      (lead_w)
  );

  assign carry_w = dp_carry & ~za & ~zb;

  always_comb begin
    if (za && zb) nxt = '0;
    else if (za)  nxt = b_eff_w;
    else if (zb)  nxt = a_w;
    else          nxt = dp_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

// File: rtl/bf16_addsub_chk.sv
module bf16_addsub_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] op_a,
  input logic [15:0] op_b,
  input logic        sub_sel,
  input logic        out_valid,
  input logic [15:0] result,
  input logic        carry_w,
  input logic [7:0]  big_exp_w,
  input logic        cancel_w,
  input logic        lead_w,
  input logic        eff_sub_w,
  input logic        swap_w
);
  logic a_nz, b_nz;
  assign a_nz = op_a[14:0] != 15'd0;
  assign b_nz = op_b[14:0] != 15'd0;

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R3
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  cancel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op_a[14:0] == op_b[14:0]) && (op_a[15] != (op_b[15] ^ sub_sel))
    |=> result == 16'h0000);
  // R4
  b_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && a_nz && !b_nz |=> result == $past(op_a));
  // R4
  a_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !a_nz && b_nz
    |=> result == {$past(op_b[15] ^ sub_sel), $past(op_b[14:0])});
  // R5
  wide_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && a_nz && b_nz && ({1'b0, op_a[14:7]} >= {1'b0, op_b[14:7]} + 9'd8)
    |=> result == $past(op_a));
  // R6
  carry_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && carry_w |=> result[14:7] == $past(big_exp_w) + 8'd1);
  // R7
  norm_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && eff_sub_w && !cancel_w |-> lead_w);
  // R7
  swap_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && a_nz && b_nz && swap_w && eff_sub_w && !cancel_w
    |=> result[15] == $past(op_b[15] ^ sub_sel));
endmodule

bind bf16_addsub bf16_addsub_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .sub_sel   (sub_sel),
  .out_valid (out_valid),
  .result    (result),
  .carry_w   (carry_w),
  .big_exp_w (big_exp_w),
  .cancel_w  (cancel_w),
  .lead_w    (lead_w),
  .eff_sub_w (eff_sub_w),
  .swap_w    (swap_w)
);

// File: tb/test_bf16_addsub.sv
module test_bf16_addsub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        sub_sel = 1'b0;
  logic        out_valid;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bf16_addsub i_bf16_addsub (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .sub_sel   (sub_sel),
    .out_valid (out_valid),
    .result    (result)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // integer model: signed significands, iterative normalization
  function automatic logic [15:0] model(logic [15:0] a, logic [15:0] b, logic s);
    logic [15:0] bb, hi, lo;
    int d, vh, vl, tot, mag, e;
    bb = {b[15] ^ s, b[14:0]};
    if (a[14:0] == 0 && bb[14:0] == 0) return 16'h0000;
    if (a[14:0] == 0) return bb;
    if (bb[14:0] == 0) return a;
    if (a[14:0] >= bb[14:0]) begin hi = a; lo = bb; end
    else begin hi = bb; lo = a; end
    d  = int'(hi[14:7]) - int'(lo[14:7]);
    vh = 128 + int'(hi[6:0]);
    vl = (d >= 8) ? 0 : ((128 + int'(lo[6:0])) >> d);
    if (hi[15]) vh = -vh;
    if (lo[15]) vl = -vl;
    tot = vh + vl;
    if (tot == 0) return 16'h0000;
    mag = (tot < 0) ? -tot : tot;
    e = int'(hi[14:7]);
    while (mag >= 256) begin mag = mag >> 1; e++; end
    while (mag < 128) begin mag = mag << 1; e--; end
    return {hi[15], e[7:0], mag[6:0]};
  endfunction

  // present one pair, sample the registered answer after the next edge
  task automatic run(logic [15:0] a, logic [15:0] b, logic s, output logic [15:0] r);
    op_a = a; op_b = b; sub_sel = s; in_valid = 1'b1;
    @(negedge clk);
    r = result;
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R3: out_valid got %b expected 1", out_valid);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R3 reset result", result, 16'h0000);
    check("R3 reset valid", {15'd0, out_valid}, 16'h0000);
  endtask

  task automatic t_basic;
    logic [15:0] r;
    run(16'h3F40, 16'h40A0, 1'b1, r); check("R2 sub example", r, 16'hC088);
    run(16'h3F40, 16'h40A0, 1'b0, r); check("R2 add example", r, 16'h40B8);
    @(negedge clk);
    check("R3 idle valid", {15'd0, out_valid}, 16'h0000);
    check("R3 result held", result, 16'h40B8);
  endtask

  task automatic t_zero;
    logic [15:0] r;
    run(16'h40A0, 16'h0000, 1'b0, r); check("R4 x+0", r, 16'h40A0);
    run(16'h0000, 16'hC088, 1'b0, r); check("R4 0+y", r, 16'hC088);
    run(16'h0000, 16'h40A0, 1'b1, r); check("R4 0-y", r, 16'hC0A0);
    run(16'h8000, 16'h3F80, 1'b0, r); check("R1 negative zero", r, 16'h3F80);
    run(16'h8000, 16'h0000, 1'b1, r); check("R4 both zero", r, 16'h0000);
  endtask

  task automatic t_cancel;
    logic [15:0] r;
    run(16'h40A0, 16'h40A0, 1'b1, r); check("R8 x-x", r, 16'h0000);
    run(16'h40A0, 16'hC0A0, 1'b0, r); check("R8 x+(-x)", r, 16'h0000);
  endtask

  task automatic t_align;
    logic [15:0] r;
    run(16'h4300, 16'h3F80, 1'b0, r); check("R5 gap 7", r, 16'h4301);
    run(16'h4380, 16'h3F80, 1'b0, r); check("R5 gap 8", r, 16'h4380);
    run(16'h3F80, 16'h4380, 1'b1, r); check("R5 gap 8 swapped", r, 16'hC380);
  endtask

  task automatic t_add_carry;
    logic [15:0] r;
    run(16'h3F80, 16'h3F80, 1'b0, r); check("R6 carry", r, 16'h4000);
    run(16'hBF80, 16'hBF80, 1'b0, r); check("R6 negative carry", r, 16'hC000);
    run(16'hBF80, 16'h3F80, 1'b1, r); check("R6 neg minus pos", r, 16'hC000);
  endtask

  task automatic t_sub_norm;
    logic [15:0] r;
    run(16'h3F80, 16'h3F7F, 1'b1, r); check("R7 deep normalize", r, 16'h3C00);
    run(16'h3F80, 16'h4000, 1'b1, r); check("R7 swap sign", r, 16'hBF80);
    run(16'h3FC0, 16'h3FE0, 1'b1, r); check("R7 same exponent", r, 16'hBE80);
  endtask

  task automatic t_random;
    logic [15:0] r, a, b, e;
    logic s;
    for (int i = 0; i < 300; i++) begin
      a = {1'($urandom), 8'(8'h60 + ($urandom % 64)), 7'($urandom)};
      b = {1'($urandom), 8'(8'h60 + ($urandom % 64)), 7'($urandom)};
      s = 1'($urandom);
      e = model(a, b, s);
      run(a, b, s, r);
      check((s ? "R7 random pair" : "R6 random pair"), r, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_zero();
    t_cancel();
    t_align();
    t_add_carry();
    t_sub_norm();
    t_random();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule